// File: doc/BRIEF.md
# Tagged Resource-Item Stream Parser

This block follows the byte stream of tagged resource items that an add-in card returns after its identifier, one byte for each cycle in which `in_valid` is high. For every byte it says what that byte is: an item header, one of the two length bytes of a large item, a payload byte, and whether it is the last byte of its item. While an item is in flight it reports the item's format (small or large), its name, its payload length, a classification code, a flag for descriptors that software later turns into configuration registers, and a running index that follows stream order.

All strobes and item fields are combinational views of the current beat. They are valid in the same cycle as the byte and are qualified by `in_valid`. The stream closes with an end item, and the byte that follows it is the checksum. Once the checksum has been accepted the parser raises `done` and ignores its input until it is reset. Decoding descriptor fields and acting on them is left to logic downstream.

Top module: `res_item_parser`

## Requirements
- R1: While `rst_n` is low at a clock edge the parser returns to expecting a header, clears `item_idx` to 0 and drops `done`. After reset the first accepted byte is taken as a header.
- R2: A header with bit 7 = 0 is a small item. Its name is bits 6:3 and its payload length is bits 2:0. `beat_hdr` is high on the header beat, `beat_pay` is high on each of the following length bytes, and `beat_last` is high on the final payload byte.
- R3: A small item whose length field is 0 (other than the end item) has a header beat only, and that beat also raises `beat_last`.
- R4: A header with bit 7 = 1 is a large item with name = bits 6:0. The next two bytes are its length, low byte first, each marked by `beat_len`. The payload beats follow. A length of 0 raises `beat_last` on the high length byte.
- R5: `item_kind` encodes the item: 0 other, 1 version (small 0x1), 2 logical device ID (small 0x2), 3 compatible ID (small 0x3), 4 IRQ (small 0x4), 5 DMA (small 0x5), 6 I/O port (small 0x8), 7 24-bit memory (large 0x01), 8 ANSI identifier string (large 0x02), 9 32-bit memory (large 0x05), 10 end (small 0xF). `item_interest` is high for codes 2, 4, 5, 6, 7 and 9.
- R6: `item_idx` is the same on every beat of one item. It rises by exactly one after each item's last beat, so items are numbered in stream order from 0.
- R7: The end item (small name 0xF, normally header 0x79) is always followed by exactly one checksum byte, whatever its length field holds. That byte raises `beat_pay`, `beat_last` and `beat_cksum`, and from the next cycle `done` is high.
- R8: While `done` is high, no strobe rises, `item_idx` does not change and `done` stays high until reset, whatever arrives on `in_byte`/`in_valid`.
- R9: `fmt_err` pulses on the header beat of a small item with a known name whose length field is outside its allowed set: version {2}, logical device ID {5,6}, compatible ID {4}, IRQ {2,3}, DMA {2}, I/O port {7}, end {1}.
- R10: In a cycle with `in_valid` low no strobe is raised and no parser state advances.
- R11: `item_len` gives the payload length on a small item's header beat, on a large item's high length byte, and on every payload beat. `item_name` and `item_large` hold for the whole item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| beat_hdr | output | 1 | Current byte is an item header |
| beat_len | output | 1 | Current byte is a large-item length byte |
| beat_pay | output | 1 | Current byte is a payload byte |
| beat_last | output | 1 | Current byte closes its item |
| beat_cksum | output | 1 | Current byte is the closing checksum |
| fmt_err | output | 1 | Known small item with an illegal length |
| item_large | output | 1 | Current item uses the large format |
| item_name | output | 7 | Item name (small names zero-extended) |
| item_len | output | 16 | Payload length of the current item |
| item_kind | output | 4 | Classification code (see R5) |
| item_interest | output | 1 | Item is a resource or device-ID descriptor |
| item_idx | output | IDX_W | Running item index in stream order |
| done | output | 1 | Checksum accepted; input ignored |

## Verification
The stream mixes a zero-length small item, a zero-length large item, and an idle cycle between items. A parser that mishandles these either waits for payload that never comes and swallows the next header, or skips an index. An end header with a zero length field checks that the checksum byte is still collected rather than taken as a new header. An IRQ item of length 1 must raise the format flag while still being walked correctly. Bytes fed after the checksum look like a valid header, so a parser that does not stop would number them as a new item.

// File: rtl/rip_pkg.sv
// Shared types for the resource-item parser.
// Assumes: large-item length is always two bytes, so payload lengths are 16 bits wide.
package rip_pkg;
    localparam int LEN_W = 16;

    typedef enum logic [3:0] {
        K_OTHER   = 4'd0,
        K_VERSION = 4'd1,
        K_DEVID   = 4'd2,
        K_COMPAT  = 4'd3,
        K_IRQ     = 4'd4,
        K_DMA     = 4'd5,
        K_IOPORT  = 4'd6,
        K_MEM24   = 4'd7,
        K_ANSI    = 4'd8,
        K_MEM32   = 4'd9,
        K_END     = 4'd10
    } kind_e;

    typedef enum logic [2:0] {
        ST_HDR, ST_LEN_LO, ST_LEN_HI, ST_PAY, ST_DONE
    } pstate_e;

    // True for descriptors that later map to configuration registers.
    function automatic logic kind_of_interest(input kind_e k);
        return (k == K_DEVID) || (k == K_IRQ) || (k == K_DMA) ||
               (k == K_IOPORT) || (k == K_MEM24) || (k == K_MEM32);
    endfunction
endpackage

// File: rtl/rip_small_decode.sv
// Decodes a small-item header byte: name, length field, kind, legality.
// Assumes: the caller only looks at the result when bit 7 of the byte is 0.
module rip_small_decode
    import rip_pkg::*;
(
    input  logic [7:0] hdr_byte,
    output logic [3:0] name,
    output logic [2:0] len_field,
    output kind_e      kind,
    output logic       len_bad
);
    assign name      = hdr_byte[6:3];
    assign len_field = hdr_byte[2:0];

    // Map the small name to a kind and check its length against the allowed set.
    always_comb begin
        kind    = K_OTHER;
        len_bad = 1'b0;
        case (name)
            4'h1: begin kind = K_VERSION; len_bad = (len_field != 3'd2); end
            4'h2: begin kind = K_DEVID;   len_bad = (len_field != 3'd5) && (len_field != 3'd6); end
            4'h3: begin kind = K_COMPAT;  len_bad = (len_field != 3'd4); end
            4'h4: begin kind = K_IRQ;     len_bad = (len_field != 3'd2) && (len_field != 3'd3); end
            4'h5: begin kind = K_DMA;     len_bad = (len_field != 3'd2); end
            4'h8: begin kind = K_IOPORT;  len_bad = (len_field != 3'd7); end
            4'hF: begin kind = K_END;     len_bad = (len_field != 3'd1); end
            default: begin kind = K_OTHER; len_bad = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rip_large_kind.sv
// Maps a large-item name to its kind code.
// Assumes: unknown large names are reported as K_OTHER and walked normally.
module rip_large_kind
    import rip_pkg::*;
(
    input  logic [6:0] name,
    output kind_e      kind
);
    // Known large names only; everything else is other.
    always_comb begin
        case (name)
            7'h01:   kind = K_MEM24;
            7'h02:   kind = K_ANSI;
            7'h05:   kind = K_MEM32;
            default: kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/rip_pay_counter.sv
// Payload down-counter: loaded with a length, decremented per payload byte.
// Assumes: load and dec are never high together, and dec only while remain > 0.
module rip_pay_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] remain,
    output logic          is_last
);
    // Hold the number of payload bytes still expected.
    always_ff @(posedge clk) begin
        if (!rst_n)    remain <= '0;
        else if (load) remain <= load_val;
        else if (dec)  remain <= remain - CW'(1);
    end

    assign is_last = (remain == CW'(1));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remain != '0));
endmodule

// File: rtl/res_item_parser.sv
// Walks a tagged resource-item byte stream and reports the role of each byte.
// Assumes: one byte per in_valid cycle; the stream starts on an item header
// after reset; the byte after the end item is the checksum.
module res_item_parser
    import rip_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              beat_hdr,
    output logic              beat_len,
    output logic              beat_pay,
    output logic              beat_last,
    output logic              beat_cksum,
    output logic              fmt_err,
    output logic              item_large,
    output logic [6:0]        item_name,
    output logic [15:0]       item_len,
    output logic [3:0]        item_kind,
    output logic              item_interest,
    output logic [IDX_W-1:0]  item_idx,
    output logic              done
);
    pstate_e           state;
    logic [6:0]        name_q;
    logic              large_q;
    kind_e             kind_q;
    logic [7:0]        lo_q;
    logic [LEN_W-1:0]  len_q;
    logic              end_q;
    logic [IDX_W-1:0]  idx_q;

    logic [3:0]        s_name;
    logic [2:0]        s_len;
    kind_e             s_kind;
    logic              s_bad;
    kind_e             l_kind;
    logic [LEN_W-1:0]  remain;
    logic              pay_last;

    rip_small_decode u_sdec (
        .hdr_byte (in_byte),
        .name     (s_name),
        .len_field(s_len),
        .kind     (s_kind),
        .len_bad  (s_bad)
    );

    rip_large_kind u_lkind (
        .name (in_byte[6:0]),
        .kind (l_kind)
    );

    logic              acc;
    logic              is_large_hdr;
    logic              s_is_end;
    logic [2:0]        s_eff_len;
    logic [LEN_W-1:0]  len_full;
    kind_e             hdr_kind;
    kind_e             cur_kind;
    logic              ld_small;
    logic              ld_large;

    assign acc          = in_valid && (state != ST_DONE);
    assign is_large_hdr = in_byte[7];
    assign s_is_end     = (s_kind == K_END);
    assign s_eff_len    = s_is_end ? 3'd1 : s_len;
    assign len_full     = {in_byte, lo_q};
    assign hdr_kind     = is_large_hdr ? l_kind : s_kind;

    assign ld_small = acc && (state == ST_HDR) && !is_large_hdr && (s_eff_len != 3'd0);
    assign ld_large = acc && (state == ST_LEN_HI) && (len_full != '0);

    rip_pay_counter #(.CW(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_small || ld_large),
        .load_val(ld_small ? LEN_W'(s_eff_len) : len_full),
        .dec     (acc && (state == ST_PAY)),
        .remain  (remain),
        .is_last (pay_last)
    );

    // Per-beat strobes derived from the walk position.
    always_comb begin
        beat_hdr   = acc && (state == ST_HDR);
        beat_len   = acc && ((state == ST_LEN_LO) || (state == ST_LEN_HI));
        beat_pay   = acc && (state == ST_PAY);
        beat_cksum = beat_pay && end_q;
        beat_last  = (beat_hdr && !is_large_hdr && (s_eff_len == 3'd0)) ||
                     (acc && (state == ST_LEN_HI) && (len_full == '0)) ||
                     (beat_pay && pay_last);
        fmt_err    = beat_hdr && !is_large_hdr && s_bad;
    end

    // Item fields: decoded live on the header beat, held afterwards.
    always_comb begin
        if (state == ST_HDR) begin
            item_large = is_large_hdr;
            item_name  = is_large_hdr ? in_byte[6:0] : {3'b000, s_name};
            cur_kind   = hdr_kind;
            item_len   = is_large_hdr ? '0 : LEN_W'(s_eff_len);
        end else begin
            item_large = large_q;
            item_name  = name_q;
            cur_kind   = kind_q;
            item_len   = (state == ST_LEN_HI) ? len_full : len_q;
        end
        item_kind     = cur_kind;
        item_interest = kind_of_interest(cur_kind);
    end

    assign item_idx = idx_q;
    assign done     = (state == ST_DONE);

    // Walk state machine and held item context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HDR;
            name_q  <= '0;
            large_q <= 1'b0;
            kind_q  <= K_OTHER;
            lo_q    <= '0;
            len_q   <= '0;
            end_q   <= 1'b0;
            idx_q   <= '0;
        end else if (acc) begin
            case (state)
                ST_HDR: begin
                    large_q <= is_large_hdr;
                    name_q  <= item_name;
                    kind_q  <= hdr_kind;
                    end_q   <= !is_large_hdr && s_is_end;
                    len_q   <= is_large_hdr ? '0 : LEN_W'(s_eff_len);
                    if (is_large_hdr)           state <= ST_LEN_LO;
                    else if (s_eff_len == 3'd0) state <= ST_HDR;
                    else                        state <= ST_PAY;
                end
                ST_LEN_LO: begin
                    lo_q  <= in_byte;
                    state <= ST_LEN_HI;
                end
                ST_LEN_HI: begin
                    len_q <= len_full;
                    state <= (len_full == '0) ? ST_HDR : ST_PAY;
                end
                ST_PAY: begin
                    if (pay_last) state <= end_q ? ST_DONE : ST_HDR;
                end
                default: state <= ST_DONE;
            endcase
            if (beat_last) idx_q <= idx_q + IDX_W'(1);
        end
    end

    // R2
    beat_class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beat_hdr, beat_len, beat_pay}));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |=> (item_idx == $past(item_idx) + IDX_W'(1)));

    // R7
    done_after_cksum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(beat_cksum));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(item_idx)));
endmodule

// File: tb/res_item_parser_bench.sv
module res_item_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        beat_hdr, beat_len, beat_pay, beat_last, beat_cksum, fmt_err;
    logic        item_large, item_interest, done;
    logic [6:0]  item_name;
    logic [15:0] item_len;
    logic [3:0]  item_kind;
    logic [7:0]  item_idx;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    res_item_parser #(.IDX_W(8)) u_res_item_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .beat_hdr(beat_hdr), .beat_len(beat_len), .beat_pay(beat_pay),
        .beat_last(beat_last), .beat_cksum(beat_cksum), .fmt_err(fmt_err),
        .item_large(item_large), .item_name(item_name), .item_len(item_len),
        .item_kind(item_kind), .item_interest(item_interest),
        .item_idx(item_idx), .done(done)
    );

    // flags: hdr len pay last cksum err interest
    typedef struct packed {
        logic       v;
        logic [7:0] b;
        logic [6:0] f;
        logic [3:0] k;
        logic [7:0] i;
        logic       d;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h0A, 7'b1000000, 4'd1,  8'd0, 1'b0},  // version hdr R2 R5
        '{1'b1, 8'h10, 7'b0010000, 4'd1,  8'd0, 1'b0},
        '{1'b1, 8'h00, 7'b0011000, 4'd1,  8'd0, 1'b0},
        '{1'b0, 8'hFF, 7'b0000000, 4'd0,  8'd1, 1'b0},  // idle R10
        '{1'b1, 8'h15, 7'b1000001, 4'd2,  8'd1, 1'b0},  // device id len 5
        '{1'b1, 8'h41, 7'b0010001, 4'd2,  8'd1, 1'b0},
        '{1'b1, 8'h42, 7'b0010001, 4'd2,  8'd1, 1'b0},
        '{1'b1, 8'h43, 7'b0010001, 4'd2,  8'd1, 1'b0},
        '{1'b1, 8'h44, 7'b0010001, 4'd2,  8'd1, 1'b0},
        '{1'b1, 8'h45, 7'b0011001, 4'd2,  8'd1, 1'b0},
        '{1'b1, 8'h30, 7'b1001000, 4'd0,  8'd2, 1'b0},  // zero-length small R3
        '{1'b1, 8'h23, 7'b1000001, 4'd4,  8'd3, 1'b0},  // IRQ len 3
        '{1'b1, 8'h01, 7'b0010001, 4'd4,  8'd3, 1'b0},
        '{1'b1, 8'h02, 7'b0010001, 4'd4,  8'd3, 1'b0},
        '{1'b1, 8'h03, 7'b0011001, 4'd4,  8'd3, 1'b0},
        '{1'b1, 8'h82, 7'b1000000, 4'd8,  8'd4, 1'b0},  // ANSI string R4
        '{1'b1, 8'h03, 7'b0100000, 4'd8,  8'd4, 1'b0},
        '{1'b1, 8'h00, 7'b0100000, 4'd8,  8'd4, 1'b0},
        '{1'b1, 8'h61, 7'b0010000, 4'd8,  8'd4, 1'b0},
        '{1'b1, 8'h62, 7'b0010000, 4'd8,  8'd4, 1'b0},
        '{1'b1, 8'h63, 7'b0011000, 4'd8,  8'd4, 1'b0},
        '{1'b1, 8'h85, 7'b1000001, 4'd9,  8'd5, 1'b0},  // 32-bit mem, length 0
        '{1'b1, 8'h00, 7'b0100001, 4'd9,  8'd5, 1'b0},
        '{1'b1, 8'h00, 7'b0101001, 4'd9,  8'd5, 1'b0},
        '{1'b1, 8'h2A, 7'b1000001, 4'd5,  8'd6, 1'b0},  // DMA
        '{1'b1, 8'h07, 7'b0010001, 4'd5,  8'd6, 1'b0},
        '{1'b1, 8'h08, 7'b0011001, 4'd5,  8'd6, 1'b0},
        '{1'b1, 8'h21, 7'b1000011, 4'd4,  8'd7, 1'b0},  // IRQ len 1: R9
        '{1'b1, 8'h55, 7'b0011001, 4'd4,  8'd7, 1'b0},
        '{1'b1, 8'h79, 7'b1000000, 4'd10, 8'd8, 1'b0},  // end R7
        '{1'b1, 8'hAB, 7'b0011100, 4'd10, 8'd8, 1'b0},  // checksum
        '{1'b1, 8'h0A, 7'b0000000, 4'd0,  8'd9, 1'b1}   // ignored R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] b);
        @(posedge clk);
        #1;
        in_valid = v;
        in_byte  = b;
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0);
        chk("R1 idx", item_idx, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int n = 0; n < NV; n++) begin
            drive(VEC[n].v, VEC[n].b);
            chk("R2/R4 strobes", {beat_hdr, beat_len, beat_pay, beat_last, beat_cksum, fmt_err},
                VEC[n].f[6:1]);
            chk("R6 idx", item_idx, VEC[n].i);
            chk("R8 done", done, VEC[n].d);
            if (VEC[n].f[6:4] != 3'b000) begin
                chk("R5 kind", item_kind, VEC[n].k);
                chk("R5 interest", item_interest, VEC[n].f[0]);
            end
        end

        // R1: reset clears done and index
        do_reset();
        @(negedge clk);
        chk("R1 done cleared", done, 0);
        chk("R1 idx cleared", item_idx, 0);

        // R11: small header fields
        drive(1'b1, 8'h23);
        chk("R11 small len", item_len, 3);
        chk("R11 small name", item_name, 7'h4);
        chk("R11 small large", item_large, 0);
        drive(1'b1, 8'h00);
        drive(1'b1, 8'h00);
        drive(1'b1, 8'h00);
        // R4/R11: large item fields on payload
        drive(1'b1, 8'h82);
        chk("R4 large flag", item_large, 1);
        drive(1'b1, 8'h03);
        drive(1'b1, 8'h00);
        chk("R11 len on high byte", item_len, 3);
        drive(1'b1, 8'h11);
        chk("R11 payload len", item_len, 3);
        chk("R11 payload name", item_name, 7'h02);
        chk("R11 payload large", item_large, 1);
        // R10: idle in mid-payload does not advance
        drive(1'b0, 8'h00);
        chk("R10 idle no strobe", {beat_hdr, beat_len, beat_pay, beat_last}, 4'b0000);
        drive(1'b1, 8'h12);
        chk("R10 still payload", {beat_pay, beat_last}, 2'b10);
        drive(1'b1, 8'h13);
        chk("R10 last after idle", {beat_pay, beat_last}, 2'b11);
        chk("R6 idx second item", item_idx, 1);

        // R7/R9: end header with zero length field still takes a checksum
        drive(1'b1, 8'h78);
        chk("R9 end len err", fmt_err, 1);
        chk("R7 end hdr not last", beat_last, 0);
        drive(1'b1, 8'h5A);
        chk("R7 cksum", {beat_pay, beat_last, beat_cksum}, 3'b111);
        drive(1'b0, 8'h00);
        chk("R7 done", done, 1);
        drive(1'b1, 8'h79);
        chk("R8 ignored hdr", beat_hdr, 0);
        chk("R8 idx frozen", item_idx, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule